// File: doc/BRIEF.md
# Framed Command UART Receiver

This block receives command packets from a serial line for a small soft processor. It deserializes each byte by oversampling the line and writes it into a 16-byte packet buffer. It tells the processor only when a complete packet is present and its format identifier is valid. The processor never handles single bytes. It waits for one level interrupt, reads the buffer through a byte-addressed read port and pulses an acknowledge strobe to release the buffer.

Every packet is 16 bytes long. Byte 0 carries the format identifier. The identifier must be one of a small set fixed by a parameter, so several packet formats, including an older one, can share the link. Packets with an unknown identifier are dropped without notice. If the line goes quiet in the middle of a packet, the partial packet is discarded and the receiver starts again at the next byte. A simple byte-wise transmitter is provided for sending responses.

Top module: `cmd_uart`

## Requirements
- R1: The serial format is 1 start bit (low), 8 data bits sent LSB first, no parity, and 1 stop bit (high). One bit lasts 16 oversampling ticks, and one tick lasts `div_i` clock cycles. A `div_i` of 0 is treated as 1.
- R2: Received bytes are stored in arrival order. While `irq_o` is high, `rd_data_o` shows packet byte k when `rd_addr_i` = k, for k = 0 to 15.
- R3: `irq_o` rises only after the 16th byte of a packet has been stored. It stays low after 15 bytes.
- R4: A packet whose byte 0 is not in the accepted set is dropped and does not raise `irq_o`. The next byte starts a new packet.
- R5: The default accepted identifier set is {0x41, 0x4C, 0x50}. A packet carrying any one of these values is delivered.
- R6: Inside a packet, if no byte completes for `idle_limit_i` ticks, the bytes gathered so far are discarded and the next byte becomes byte 0. A value of 0 turns the timeout off.
- R7: While `irq_o` is high and no acknowledge has been given, incoming bytes are ignored and the buffer is left unchanged. Each such byte sets the sticky `overrun_o`.
- R8: A one-cycle pulse on `ack_i` clears `irq_o` and `overrun_o` on the next clock edge and re-arms reception at byte 0.
- R9: When `tx_valid_i` is high while `tx_ready_o` is high, the byte is sent on `tx_o` in the R1 format. `tx_ready_o` stays low until the stop bit has finished. `tx_o` idles high.
- R10: After reset, `irq_o` = 0, `overrun_o` = 0, `tx_o` = 1 and `tx_ready_o` = 1.
- R11: A byte whose stop bit is sampled low is discarded and not stored. The receiver waits for the line to go high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| div_i | input | DIV_W | Clock cycles per oversampling tick |
| idle_limit_i | input | IDLE_W | Timeout inside a packet, in ticks (0 turns it off) |
| rd_addr_i | input | 4 | Buffer byte index |
| rd_data_o | output | 8 | Buffer byte at `rd_addr_i` |
| ack_i | input | 1 | Release the packet and clear the interrupt |
| irq_o | output | 1 | A valid packet is ready |
| overrun_o | output | 1 | Sticky flag: bytes arrived while a packet was pending |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit request |
| tx_ready_o | output | 1 | Transmitter is idle |

## Verification
The hardest conditions to reach from the ports are those that depend on the timing between bytes. These are a partial packet expiring and a malformed byte landing in the middle of a packet. The bench sends 5 bytes and then holds the line idle for longer than the timeout. It follows with a full packet whose identifier is valid, so a missing timeout would show up as shifted packet contents rather than as a silent pass. A byte with a low stop bit is sent between two halves of a good packet, and the bench expects only the good bytes in the buffer. Overrun is reached by switching off the automatic acknowledge in the monitor, so that more bytes arrive while a packet is still pending.

// File: rtl/cmd_uart_pkg.sv
package cmd_uart_pkg;
  localparam int PKT_BYTES = 16;
  localparam int ADDR_W    = $clog2(PKT_BYTES);
  localparam int OSR       = 16;
  localparam int OSR_W     = $clog2(OSR);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/cu_tick_gen.sv
module cu_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] tcnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = (tcnt_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tcnt_q <= '0;
    else if (tick_o) tcnt_q <= '0;
    else             tcnt_q <= tcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/cu_rx_core.sv
module cu_rx_core
  import cmd_uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o
);
  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        st_q;
  logic [OSR_W-1:0] ph_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             vld_q;

  assign rx_s         = sync_q[1];
  assign byte_valid_o = vld_q;
  assign byte_o       = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      vld_q  <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_q <= RX_START;
          ph_q <= '0;
        end
        RX_START: if (tick_i) begin
          if (ph_q == OSR_W'(OSR/2 - 1)) begin
            ph_q  <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_DATA;  // glitch filter
          end else ph_q <= ph_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (ph_q == OSR_W'(OSR - 1)) begin
            ph_q <= '0;
            sh_q <= {rx_s, sh_q[7:1]};
            if (bit_q == 3'd7) st_q <= RX_STOP;
            else               bit_q <= bit_q + 1'b1;
          end else ph_q <= ph_q + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (ph_q == OSR_W'(OSR - 1)) begin
            ph_q  <= '0;
            vld_q <= rx_s;
            st_q  <= rx_s ? RX_IDLE : RX_WAIT_HI;
          end else ph_q <= ph_q + 1'b1;
        end
        RX_WAIT_HI: if (rx_s) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  // R11
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_q) |-> $past(rx_s));
endmodule

// File: rtl/cu_tx_core.sv
module cu_tx_core
  import cmd_uart_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       tx_o
);
  logic             busy_q;
  logic [9:0]       sh_q;
  logic [OSR_W-1:0] ph_q;
  logic [3:0]       cnt_q;

  assign ready_o = !busy_q;
  assign tx_o    = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      ph_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        ph_q   <= '0;
        cnt_q  <= '0;
      end
    end else if (tick_i) begin
      if (ph_q == OSR_W'(OSR - 1)) begin
        ph_q <= '0;
        sh_q <= {1'b1, sh_q[9:1]};
        if (cnt_q == 4'd9) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q + 1'b1;
      end else ph_q <= ph_q + 1'b1;
    end
  end

  // R9
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_o);
  // R9
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!tx_o && !ready_o));
endmodule

// File: rtl/cu_pkt_assembler.sv
module cu_pkt_assembler
  import cmd_uart_pkg::*;
#(
  parameter int                         IDLE_W    = 16,
  parameter int                         N_MAGIC   = 3,
  parameter logic [N_MAGIC-1:0][7:0]    MAGIC_SET = {8'h50, 8'h4C, 8'h41}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              ack_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PKT_BYTES - 1);

  logic [7:0]        pkt_q [PKT_BYTES];
  logic [ADDR_W-1:0] cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic              full_q, ovr_q;
  logic [N_MAGIC-1:0] hit;
  logic              magic_ok;

  for (genvar g = 0; g < N_MAGIC; g++) begin : g_magic
    assign hit[g] = (pkt_q[0] == MAGIC_SET[g]);
  end
  assign magic_ok  = |hit;
  assign rd_data_o = pkt_q[rd_addr_i];
  assign irq_o     = full_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i) begin
    if (byte_valid_i && !full_q && !ack_i) pkt_q[cnt_q] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (ack_i) begin
      cnt_q  <= '0;
      idle_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (byte_valid_i) begin
      if (full_q) ovr_q <= 1'b1;
      else begin
        idle_q <= '0;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          full_q <= magic_ok;  // byte 0 already stored
        end else cnt_q <= cnt_q + 1'b1;
      end
    end else if (tick_i && cnt_q != '0 && !full_q) begin
      if (idle_limit_i != '0 && (idle_q + IDLE_W'(1)) >= idle_limit_i) begin
        cnt_q  <= '0;
        idle_q <= '0;
      end else idle_q <= idle_q + IDLE_W'(1);
    end
  end

  // R3
  irq_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(byte_valid_i));
  // R4
  magic_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> magic_ok);
  // R7
  hold_buffer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !ack_i) |=> ($stable(pkt_q[0]) && $stable(pkt_q[PKT_BYTES-1])));
  // R7
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && byte_valid_i && !ack_i) |=> ovr_q);
  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!full_q && !ovr_q));
endmodule

// File: rtl/cmd_uart.sv
module cmd_uart
  import cmd_uart_pkg::*;
#(
  parameter int                      DIV_W     = 8,
  parameter int                      IDLE_W    = 16,
  parameter int                      N_MAGIC   = 3,
  parameter logic [N_MAGIC-1:0][7:0] MAGIC_SET = {8'h50, 8'h4C, 8'h41}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rx_i,
  output logic                          tx_o,
  input  logic [DIV_W-1:0]              div_i,
  input  logic [IDLE_W-1:0]             idle_limit_i,
  input  logic [cmd_uart_pkg::ADDR_W-1:0] rd_addr_i,
  output logic [7:0]                    rd_data_o,
  input  logic                          ack_i,
  output logic                          irq_o,
  output logic                          overrun_o,
  input  logic [7:0]                    tx_data_i,
  input  logic                          tx_valid_i,
  output logic                          tx_ready_o
);
  logic       tick;
  logic       rx_vld;
  logic [7:0] rx_byte;

  cu_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  cu_rx_core u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i),
    .byte_valid_o(rx_vld), .byte_o(rx_byte)
  );

  cu_pkt_assembler #(
    .IDLE_W(IDLE_W), .N_MAGIC(N_MAGIC), .MAGIC_SET(MAGIC_SET)
  ) u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .byte_valid_i(rx_vld), .byte_i(rx_byte), .ack_i(ack_i),
    .idle_limit_i(idle_limit_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .overrun_o(overrun_o)
  );

  cu_tx_core u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .data_i(tx_data_i), .valid_i(tx_valid_i),
    .ready_o(tx_ready_o), .tx_o(tx_o)
  );
endmodule

// File: tb/sim_cmd_uart.sv
`timescale 1ns/1ps
module sim_cmd_uart;
  localparam int DIV   = 2;
  localparam int BIT   = 16 * DIV;
  localparam int LIMIT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx;
  logic [7:0] div = 8'(DIV);
  logic [15:0] idle_limit = 16'(LIMIT);
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ack = 1'b0;
  logic irq, ovr;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;

  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;
  logic [127:0] exp_q [$];
  logic [7:0]   txq [$];

  always #4 clk = ~clk;

  cmd_uart u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx), .div_i(div),
    .idle_limit_i(idle_limit), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ack_i(ack), .irq_o(irq), .overrun_o(ovr), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [7:0] magic, input logic [7:0] seed);
    logic [127:0] p;
    p[7:0] = magic;
    for (int k = 1; k < 16; k++) p[8*k +: 8] = seed + 8'(k * 7);
    return p;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = good_stop;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    if (!good_stop) repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic send_range(input logic [127:0] p, input int lo, input int hi);
    for (int k = lo; k <= hi; k++) send_byte(p[8*k +: 8], 1'b1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, req, "expected packet not delivered", exp_q.size(), 0);
    exp_q.delete();
    repeat (4) @(negedge clk);
  endtask

  // packet monitor: pops the expected packet and acknowledges it
  initial begin
    logic [127:0] got;
    logic [127:0] exp;
    forever begin
      @(negedge clk);
      if (irq === 1'b1 && mon_en) begin
        for (int k = 0; k < 16; k++) begin
          rd_addr = 4'(k);
          #1;
          got[8*k +: 8] = rd_data;
        end
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected packet", got, 0);
        else begin
          exp = exp_q.pop_front();
          // R1 R2 R5: contents in order
          chk(got === exp, "R2", "packet contents", got, exp);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  // transmit monitor
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge tx);
      if (rst_n) begin
        repeat (BIT / 2) @(negedge clk);
        chk(tx === 1'b0, "R9", "start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = tx;
        end
        repeat (BIT) @(negedge clk);
        chk(tx === 1'b1, "R9", "stop bit", tx, 1);
        e = (txq.size() != 0) ? txq.pop_front() : 8'hxx;
        chk(b === e, "R9", "tx byte", b, e);
      end
    end
  end

  task automatic send_tx(input logic [7:0] b);
    while (tx_ready !== 1'b1) @(negedge clk);
    txq.push_back(b);
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, "R9", "ready low after accept", tx_ready, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R0", "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [127:0] p;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk(irq === 1'b0, "R10", "irq in reset", irq, 0);
    chk(ovr === 1'b0, "R10", "overrun in reset", ovr, 0);
    chk(tx === 1'b1, "R10", "tx idle in reset", tx, 1);
    chk(tx_ready === 1'b1, "R10", "tx_ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    repeat (BIT) @(negedge clk);

    // R5: each accepted identifier
    p = mk(8'h41, 8'h10); exp_q.push_back(p); send_range(p, 0, 15); drain("R5");
    p = mk(8'h4C, 8'h90); exp_q.push_back(p); send_range(p, 0, 15); drain("R5");

    // R4: bad identifier dropped, next packet resyncs
    p = mk(8'h33, 8'h20); send_range(p, 0, 15);
    repeat (8) @(negedge clk);
    chk(irq === 1'b0, "R4", "irq after bad identifier", irq, 0);
    p = mk(8'h50, 8'h55); exp_q.push_back(p); send_range(p, 0, 15); drain("R4");

    // R3: no irq after 15 bytes
    p = mk(8'h41, 8'hC3); exp_q.push_back(p);
    send_range(p, 0, 14);
    repeat (2 * BIT) @(negedge clk);
    chk(irq === 1'b0, "R3", "irq after 15 bytes", irq, 0);
    send_range(p, 15, 15);
    drain("R3");

    // R6: idle timeout drops partial packet
    p = mk(8'h41, 8'h01); send_range(p, 0, 4);
    repeat (LIMIT * DIV + 500) @(negedge clk);
    chk(irq === 1'b0, "R6", "irq after partial", irq, 0);
    p = mk(8'h4C, 8'h77); exp_q.push_back(p); send_range(p, 0, 15); drain("R6");

    // R11: byte with low stop bit is not stored
    p = mk(8'h50, 8'hE0); exp_q.push_back(p);
    send_range(p, 0, 7);
    send_byte(8'hEE, 1'b0);
    send_range(p, 8, 15);
    drain("R11");

    // R7 / R8: overrun while pending, then acknowledge
    mon_en = 1'b0;
    p = mk(8'h41, 8'h3A); send_range(p, 0, 15);
    repeat (4) @(negedge clk);
    chk(irq === 1'b1, "R3", "irq after full packet", irq, 1);
    chk(ovr === 1'b0, "R7", "no overrun yet", ovr, 0);
    send_byte(8'hAA, 1'b1); send_byte(8'hAB, 1'b1); send_byte(8'hAC, 1'b1);
    repeat (4) @(negedge clk);
    chk(ovr === 1'b1, "R7", "overrun set", ovr, 1);
    chk(irq === 1'b1, "R7", "irq held", irq, 1);
    for (int k = 0; k < 16; k++) begin
      rd_addr = 4'(k);
      #1;
      chk(rd_data === p[8*k +: 8], "R7", "buffer unchanged", rd_data, p[8*k +: 8]);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(irq === 1'b0, "R8", "irq cleared by ack", irq, 0);
    chk(ovr === 1'b0, "R8", "overrun cleared by ack", ovr, 0);
    mon_en = 1'b1;
    p = mk(8'h50, 8'h11); exp_q.push_back(p); send_range(p, 0, 15); drain("R8");

    // R9: transmit, back to back
    send_tx(8'hA5);
    send_tx(8'h3C);
    repeat (12 * BIT) @(negedge clk);
    chk(txq.size() == 0, "R9", "all tx bytes seen", txq.size(), 0);

    finish_run();
  end
endmodule